// File: doc/BRIEF.md
# Lockable PLL Divider Configuration Unit

This block keeps the settings of a clock synthesizer: a 9-bit feedback multiplier code and three 7-bit post-divider codes for outputs called P, Q and R. Software writes one full word through a plain write port and can read the word back at any time. Each field has a guard. The multiplier accepts new data only while the PLL is neither switched on nor reporting ready. Each post-divider accepts new data only while its own output enable is low. A write that tries to change a guarded field leaves that field as it was and raises a sticky status bit. Software clears that bit by writing 1 to it.

The same block generates the three divided clocks from the VCO clock. Each output has its own counter divider. The output enable is resynchronised into the VCO domain, and the output stays low while the enable is off. A combinational error flag reports a multiplier code that is too small or a P code that gives an odd ratio.

Top module: `pll_divcfg_unit`

## Requirements
- R1: After a synchronous reset, the multiplier code reads 128, which means a factor of 129. The P, Q and R codes read 1, which means divide by 2. The blocked bit reads 0, and `cfg_err_o` is 0.
- R2: The word layout is: multiplier code in [8:0], blocked bit in [9], P code in [16:10], Q code in [23:17] and R code in [30:24]. This layout applies to both `wr_data_i` and `rd_data_o`. The multiplier factor is code+1. `cfg_err_o` is 1 whenever the multiplier code is below 7.
- R3: A write leaves the multiplier code unchanged while `pll_on_i` or `pll_rdy_i` is 1. Otherwise the write takes the new code on the next clock edge.
- R4: A write leaves each post-divider code unchanged while that output's own enable is 1. The other fields still update in the same write.
- R5: The blocked bit becomes 1 after any write that carries a value different from a field that is guarded at that moment. It stays 1 until a write has bit [9] set and changes no guarded field. If both events occur in one write, setting the bit wins.
- R6: `cfg_err_o` is 1 whenever the P code is even, so only even division ratios count as legal.
- R7: For a code c ≥ 1, an output divides the VCO clock by c+1. Its high time is floor((c+1)/2) VCO cycles, followed by the rest of the period low.
- R8: A Q or R code of 0 passes the VCO clock through to the output while that output is enabled.
- R9: While an output's enable is low, the output is low. After the enable rises, the output goes high first on the third VCO rising edge. The counter restarts from zero on every new enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Register clock |
| rst_i | input | 1 | Synchronous active-high reset |
| vco_clk_i | input | 1 | VCO clock to be divided |
| wr_en_i | input | 1 | Full-word write strobe |
| wr_data_i | input | 31 | Write word (layout in R2) |
| pll_on_i | input | 1 | PLL switched on (guards the multiplier) |
| pll_rdy_i | input | 1 | PLL ready (guards the multiplier) |
| p_en_i | input | 1 | P output enable (guards the P code) |
| q_en_i | input | 1 | Q output enable (guards the Q code) |
| r_en_i | input | 1 | R output enable (guards the R code) |
| rd_data_o | output | 31 | Current configuration word |
| cfg_err_o | output | 1 | Illegal multiplier or P code |
| p_clk_o | output | 1 | Divided P clock |
| q_clk_o | output | 1 | Divided Q clock |
| r_clk_o | output | 1 | Divided R clock |

## Verification
The blocked bit has two actions that can fall in the same write: it can be cleared and it can be set. The bench provokes this case by raising the P enable and then writing a changed P code with bit [9] set. It expects the bit to read 1 afterwards and the P code to be unchanged. A later write with bit [9] set and no changed guarded field must then read the bit back as 0. The divider checks compare each VCO cycle against the expected waveform. They cover every Q code, every odd P code and a set of R codes, including the pass-through code.

// File: rtl/pll_divcfg_pkg.sv
`timescale 1ns/1ps
package pll_divcfg_pkg;
  localparam int N_OUT = 3;
  localparam int OUT_P = 0;
  localparam int OUT_Q = 1;
  localparam int OUT_R = 2;
endpackage

// File: rtl/pll_divcfg_regs.sv
`timescale 1ns/1ps
module pll_divcfg_regs
  import pll_divcfg_pkg::*;
#(
  parameter int MUL_W   = 9,
  parameter int DIV_W   = 7,
  parameter int MUL_RST = 128,
  parameter int DIV_RST = 1
) (
  input  logic                        clk_i,
  input  logic                        rst_i,
  input  logic                        wr_en_i,
  input  logic [MUL_W-1:0]            wr_mul_i,
  input  logic [N_OUT-1:0][DIV_W-1:0] wr_div_i,
  input  logic                        wr_clr_i,
  input  logic                        pll_on_i,
  input  logic                        pll_rdy_i,
  input  logic [N_OUT-1:0]            out_en_i,
  output logic [MUL_W-1:0]            mul_q,
  output logic [N_OUT-1:0][DIV_W-1:0] div_q,
  output logic                        blk_q
);
  logic mul_lock;
  logic hit;

  always_comb begin
    mul_lock = pll_on_i | pll_rdy_i;
    hit = wr_en_i & mul_lock & (wr_mul_i != mul_q);
    for (int i = 0; i < N_OUT; i++) begin
      hit = hit | (wr_en_i & out_en_i[i] & (wr_div_i[i] != div_q[i]));
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      mul_q <= MUL_W'(MUL_RST);
      for (int i = 0; i < N_OUT; i++) div_q[i] <= DIV_W'(DIV_RST);
      blk_q <= 1'b0;
    end else if (wr_en_i) begin
      if (!mul_lock) mul_q <= wr_mul_i;
      for (int i = 0; i < N_OUT; i++) begin
        if (!out_en_i[i]) div_q[i] <= wr_div_i[i];
      end
      if (hit) blk_q <= 1'b1;
      else if (wr_clr_i) blk_q <= 1'b0;
    end
  end

  // R3: multiplier frozen while PLL on or ready
  a_r3_mul_locked: assert property (@(posedge clk_i) disable iff (rst_i)
    (pll_on_i || pll_rdy_i) |=> (mul_q == $past(mul_q)));

  // R4: each post-divider frozen while its enable is set
  for (genvar g = 0; g < N_OUT; g++) begin : g_lock_chk
    a_r4_div_locked: assert property (@(posedge clk_i) disable iff (rst_i)
      out_en_i[g] |=> (div_q[g] == $past(div_q[g])));
  end

  // R5: blocked bit only falls on a clearing write
  a_r5_blk_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
    (blk_q && !(wr_en_i && wr_clr_i)) |=> blk_q);
endmodule

// File: rtl/pll_post_div.sv
`timescale 1ns/1ps
module pll_post_div #(
  parameter int DIV_W = 7
) (
  input  logic             vco_clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic [DIV_W-1:0] code_i,
  output logic             clk_o
);
  logic             sync1_q, sync2_q, en_low_q, out_q;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W:0]   half;

  assign half = ({1'b0, code_i} + (DIV_W+1)'(1)) >> 1;

  always_ff @(posedge vco_clk_i) begin
    if (rst_i) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= en_i;
      sync2_q <= sync1_q;
    end
  end

  always_ff @(posedge vco_clk_i) begin
    if (rst_i || !sync2_q) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      cnt_q <= (cnt_q == code_i) ? '0 : cnt_q + DIV_W'(1);
      out_q <= ({1'b0, cnt_q} < half);
    end
  end

  // enable copy taken while the VCO is low, so the gated pass-through has no runt
  always_ff @(negedge vco_clk_i) begin
    if (rst_i) en_low_q <= 1'b0;
    else       en_low_q <= sync2_q;
  end

  assign clk_o = (code_i == '0) ? (vco_clk_i & en_low_q) : out_q;

  // R9: divided output low while the synchronised enable is low
  a_r9_low_when_off: assert property (@(posedge vco_clk_i) disable iff (rst_i)
    !sync2_q |=> !out_q);

  // R9: first enabled edge drives the output high
  a_r9_clean_start: assert property (@(posedge vco_clk_i) disable iff (rst_i)
    ($rose(sync2_q) && code_i != '0) |=> out_q);

  // R7: counter stays inside the period
  a_r7_cnt_range: assert property (@(posedge vco_clk_i) disable iff (rst_i)
    sync2_q |-> (cnt_q <= code_i));
endmodule

// File: rtl/pll_divcfg_unit.sv
`timescale 1ns/1ps
module pll_divcfg_unit
  import pll_divcfg_pkg::*;
#(
  parameter int MUL_W   = 9,
  parameter int DIV_W   = 7,
  parameter int MUL_RST = 128,
  parameter int DIV_RST = 1,
  parameter int MUL_MIN = 7
) (
  input  logic                       clk_i,
  input  logic                       rst_i,
  input  logic                       vco_clk_i,
  input  logic                       wr_en_i,
  input  logic [MUL_W+3*DIV_W:0]     wr_data_i,
  input  logic                       pll_on_i,
  input  logic                       pll_rdy_i,
  input  logic                       p_en_i,
  input  logic                       q_en_i,
  input  logic                       r_en_i,
  output logic [MUL_W+3*DIV_W:0]     rd_data_o,
  output logic                       cfg_err_o,
  output logic                       p_clk_o,
  output logic                       q_clk_o,
  output logic                       r_clk_o
);
  localparam int CLR_BIT = MUL_W;
  localparam int DIV_LSB = MUL_W + 1;

  logic [MUL_W-1:0]            mul_q;
  logic [N_OUT-1:0][DIV_W-1:0] div_q;
  logic [N_OUT-1:0][DIV_W-1:0] wr_div;
  logic                        blk_q;
  logic [N_OUT-1:0]            out_en;
  logic [N_OUT-1:0]            div_clk;

  assign out_en = {r_en_i, q_en_i, p_en_i};

  for (genvar g = 0; g < N_OUT; g++) begin : g_field
    assign wr_div[g] = wr_data_i[DIV_LSB + g*DIV_W +: DIV_W];
  end

  pll_divcfg_regs #(
    .MUL_W(MUL_W), .DIV_W(DIV_W), .MUL_RST(MUL_RST), .DIV_RST(DIV_RST)
  ) regs_i (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .wr_en_i  (wr_en_i),
    .wr_mul_i (wr_data_i[MUL_W-1:0]),
    .wr_div_i (wr_div),
    .wr_clr_i (wr_data_i[CLR_BIT]),
    .pll_on_i (pll_on_i),
    .pll_rdy_i(pll_rdy_i),
    .out_en_i (out_en),
    .mul_q    (mul_q),
    .div_q    (div_q),
    .blk_q    (blk_q)
  );

  for (genvar g = 0; g < N_OUT; g++) begin : g_div
    pll_post_div #(.DIV_W(DIV_W)) div_i (
      .vco_clk_i(vco_clk_i),
      .rst_i    (rst_i),
      .en_i     (out_en[g]),
      .code_i   (div_q[g]),
      .clk_o    (div_clk[g])
    );
  end

  assign p_clk_o   = div_clk[OUT_P];
  assign q_clk_o   = div_clk[OUT_Q];
  assign r_clk_o   = div_clk[OUT_R];
  assign rd_data_o = {div_q, blk_q, mul_q};
  assign cfg_err_o = (mul_q < MUL_W'(MUL_MIN)) | ~div_q[OUT_P][0];
endmodule

// File: tb/pll_divcfg_unit_tb_top.sv
`timescale 1ns/1ps
module pll_divcfg_unit_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [30:0] wr_data = '0;
  logic pll_on = 1'b0, pll_rdy = 1'b0;
  logic [2:0] en_v = 3'b000;
  logic [30:0] rd;
  logic err, p_clk, q_clk, r_clk;
  int checks = 0, errors = 0;
  bit done = 0;
  int sm = 128, sp = 1, sq = 1, sr = 1;

  always #4 clk = ~clk;

  pll_divcfg_unit dut_i (
    .clk_i(clk), .rst_i(rst), .vco_clk_i(clk), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .pll_on_i(pll_on), .pll_rdy_i(pll_rdy), .p_en_i(en_v[0]), .q_en_i(en_v[1]),
    .r_en_i(en_v[2]), .rd_data_o(rd), .cfg_err_o(err), .p_clk_o(p_clk),
    .q_clk_o(q_clk), .r_clk_o(r_clk)
  );

  function automatic logic [30:0] mk(int m, int p, int q, int r, bit c);
    logic [30:0] w;
    w = '0;
    w[8:0] = m[8:0]; w[9] = c; w[16:10] = p[6:0]; w[23:17] = q[6:0]; w[30:24] = r[6:0];
    return w;
  endfunction

  function automatic logic outv(int i);
    case (i)
      0: return p_clk;
      1: return q_clk;
      default: return r_clk;
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [30:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic run_div(int idx, int code);
    int ratio, bad;
    logic e;
    ratio = code + 1;
    bad = 0;
    if (idx == 0) sp = code; else if (idx == 1) sq = code; else sr = code;
    wr(mk(sm, sp, sq, sr, 1'b0));
    for (int o = 0; o < 3; o++) if (outv(o) !== 1'b0) bad++;
    en_v[idx] = 1'b1;
    for (int j = 1; j <= 2*ratio + 6; j++) begin
      @(posedge clk); #2;
      if (code == 0) begin
        e = (j >= 3);
        if (outv(idx) !== e) bad++;
        @(negedge clk); #2;
        if (outv(idx) !== 1'b0) bad++;
      end else begin
        @(negedge clk);
        e = (j >= 3) && (((j - 3) % ratio) < ratio / 2);
        if (outv(idx) !== e) bad++;
      end
      for (int o = 0; o < 3; o++) if (o != idx && outv(o) !== 1'b0) bad++;
    end
    @(negedge clk); en_v[idx] = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    if (outv(idx) !== 1'b0) bad++;
    @(negedge clk);
    chk(bad == 0, (code == 0) ? "R8/R9 pass-through" : "R7/R9 divide", bad, 0);
  endtask

  initial begin
    #1600000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(rd == mk(128, 1, 1, 1, 1'b0), "R1 reset word", int'(rd), int'(mk(128, 1, 1, 1, 1'b0)));
    chk(err == 1'b0, "R1 reset err", int'(err), 0);

    // R2 multiplier sweep and error flag
    for (int m = 0; m < 512; m++) begin
      wr(mk(m, 1, 1, 1, 1'b0));
      chk(rd[8:0] == m[8:0] && err == (m < 7), "R2 mul code", int'({err, rd[8:0]}), int'({(m < 7), m[8:0]}));
    end
    wr(mk(128, 1, 1, 1, 1'b0));

    // R6 P code legality
    for (int p = 0; p < 128; p++) begin
      wr(mk(128, p, 1, 1, 1'b0));
      chk(rd[16:10] == p[6:0] && err == (p % 2 == 0), "R6 P code", int'({err, rd[16:10]}), int'({(p % 2 == 0), p[6:0]}));
    end
    wr(mk(128, 1, 1, 1, 1'b0));

    // R3 multiplier lock by on, then by ready; R5 set and clear
    pll_on = 1'b1;
    wr(mk(200, 1, 1, 1, 1'b0));
    chk(rd[8:0] == 128, "R3 mul locked by on", int'(rd[8:0]), 128);
    chk(rd[9] == 1'b1, "R5 blocked set", int'(rd[9]), 1);
    wr(mk(128, 1, 1, 1, 1'b1));
    chk(rd[9] == 1'b0, "R5 blocked cleared", int'(rd[9]), 0);
    pll_on = 1'b0; pll_rdy = 1'b1;
    wr(mk(300, 1, 1, 1, 1'b0));
    chk(rd[8:0] == 128, "R3 mul locked by ready", int'(rd[8:0]), 128);
    pll_rdy = 1'b0;
    wr(mk(300, 1, 1, 1, 1'b1));
    chk(rd[8:0] == 300 && rd[9] == 1'b0, "R3 mul open", int'(rd[9:0]), 300);
    wr(mk(128, 1, 1, 1, 1'b0));

    // R4 independent field locks; R5 same-write set and clear
    en_v[0] = 1'b1;
    wr(mk(128, 5, 9, 1, 1'b0));
    chk(rd[16:10] == 1, "R4 P locked", int'(rd[16:10]), 1);
    chk(rd[23:17] == 9, "R4 Q updates beside locked P", int'(rd[23:17]), 9);
    wr(mk(128, 5, 9, 1, 1'b1));
    chk(rd[9] == 1'b1 && rd[16:10] == 1, "R5 set wins over clear", int'(rd[9]), 1);
    en_v[0] = 1'b0;
    @(negedge clk);
    en_v[1] = 1'b1;
    wr(mk(128, 1, 3, 1, 1'b1));
    chk(rd[23:17] == 9 && rd[16:10] == 1, "R4 Q locked", int'(rd[23:17]), 9);
    en_v[1] = 1'b0;
    @(negedge clk);
    en_v[2] = 1'b1;
    wr(mk(128, 1, 1, 7, 1'b1));
    chk(rd[30:24] == 1 && rd[23:17] == 1, "R4 R locked", int'(rd[30:24]), 1);
    en_v[2] = 1'b0;
    repeat (4) @(negedge clk);
    wr(mk(128, 1, 1, 1, 1'b1));
    chk(rd == mk(128, 1, 1, 1, 1'b0), "R5 clear after unlock", int'(rd), int'(mk(128, 1, 1, 1, 1'b0)));

    // R7 R8 R9 divider sweeps
    for (int c = 0; c < 128; c++) run_div(1, c);
    for (int c = 1; c < 128; c += 2) run_div(0, c);
    run_div(2, 0); run_div(2, 1); run_div(2, 2); run_div(2, 6); run_div(2, 127);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule